// File: doc/BRIEF.md
# External Bus Hand-Over Arbiter

This block decides who owns the external address, data and strobe pins of a processor: the processor core or an outside master. The outside master raises a request. The arbiter waits until no external access cycle is in progress. It then asserts a grant and turns off the pin drivers. While the pins belong to the outside master, the block tells the core what it may do, through a stall output and an on-chip-only indication.

A mode input chooses between two behaviours, and the arbiter samples it at the moment the grant is taken. In halt mode the core is frozen for the whole hand-over. In run mode the core keeps executing from on-chip memory. If the core then attempts an external access, the arbiter raises a hang status output and stalls the core. The stall lasts until the outside master gives the pins back.

After the request drops, the grant falls on the next clock. One extra cycle passes with the pins still undriven, so the outside master's drivers can turn off before the core drives the pins again.

Top module: `xbus_grant_arb`

## Requirements
- R1: During and after reset, with the request low: grant, hang and stall are low, on-chip-only is low, the pin-drive indication is high, and the pins carry the core's address, data and strobes.
- R2: The grant rises on the clock edge after a cycle in which the request is high, the owned state holds, and the external-cycle-busy input is low. While busy is high, the grant stays low.
- R3: In every cycle in which the grant is high, and in the one release cycle after it, the pin-drive indication is low and all address, data and strobe pins are high impedance.
- R4: In halt mode (mode input 0 when the grant was taken), the core stall is high for every cycle the grant is high and for the release cycle. On-chip-only stays low.
- R5: In run mode (mode input 1 when the grant was taken), the core stall stays low and on-chip-only is high while the bus is away, as long as the core makes no external access.
- R6: In run mode, while the bus is away, a core external-access request raises grant-hang and core stall in the same cycle. Both stay high while the bus remains away, even if the core request drops.
- R7: When the request is low while the grant is high, the grant falls on the next clock edge. One clock later the pins are driven again, and stall and hang clear.
- R8: Changes of the mode input while the bus is away have no effect until the next grant.
- R9: After a release, the core owns the bus for at least one cycle before a new grant, even if the request is held high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busReq | input | 1 | Outside master requests the external pins |
| runWhileGranted | input | 1 | Mode: 1 = core keeps running on-chip, 0 = core halts |
| extCycleBusy | input | 1 | An external access cycle is in progress |
| coreExtReq | input | 1 | Core wants an external access this cycle |
| coreAddr | input | ADDR_W | Core address to the pins |
| coreData | input | DATA_W | Core write data to the pins |
| coreStrobe | input | STRB_W | Core strobes to the pins |
| busGrant | output | 1 | Pins handed to the outside master |
| grantHang | output | 1 | Core blocked on an external access while granted |
| coreStall | output | 1 | Core must hold |
| onChipOnly | output | 1 | Core limited to on-chip memory |
| pinsDriven | output | 1 | Pin drivers enabled |
| extAddr | output | ADDR_W | Address pins, high impedance when not driven |
| extData | output | DATA_W | Data pins, high impedance when not driven |
| extStrobe | output | STRB_W | Strobe pins, high impedance when not driven |

## Verification
The request to hand over the pins can arrive in the same cycle as an external access that is still running. The bench holds the request high while busy is high for several cycles, and confirms that the grant rises exactly one edge after busy falls. The second collision is a core external access that lands during a run-mode grant. The bench raises the core request while granted and checks, in that same cycle, that hang and stall both rise. It then drops the core request and checks that both stay high until the release completes.

// File: rtl/xbus_grant_pkg.sv
package xbus_grant_pkg;
  typedef enum logic [1:0] {
    ST_OWNED   = 2'd0,
    ST_GRANTED = 2'd1,
    ST_RELEASE = 2'd2
  } arbState_t;

  typedef struct packed {
    logic driveEn;
    logic setHang;
    logic clrHang;
    logic latchMode;
  } arbStrobes_t;
endpackage

// File: rtl/xbus_grant_ctrl.sv
module xbus_grant_ctrl
  import xbus_grant_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busReq,
  input  logic        extCycleBusy,
  input  logic        coreExtReq,
  input  logic        modeRun,
  input  logic        hangHeld,
  output arbStrobes_t strobes,
  output logic        busGrant,
  output logic        grantHang,
  output logic        coreStall,
  output logic        onChipOnly
);
  arbState_t state, stateNext;
  logic away, runAway, hangNow, takeGrant;

  always_comb begin
    stateNext = state;
    takeGrant = 1'b0;
    unique case (state)
      ST_OWNED: if (busReq && !extCycleBusy) begin
        stateNext = ST_GRANTED;
        takeGrant = 1'b1;
      end
      ST_GRANTED: if (!busReq) stateNext = ST_RELEASE;
      ST_RELEASE: stateNext = ST_OWNED;
      default:    stateNext = ST_OWNED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OWNED;
    else       state <= stateNext;
  end

  assign away    = (state != ST_OWNED);
  assign runAway = away && modeRun;
  assign hangNow = runAway && (coreExtReq || hangHeld);

  assign busGrant   = (state == ST_GRANTED);
  assign grantHang  = hangNow;
  assign onChipOnly = runAway;
  assign coreStall  = away && (!modeRun || hangNow);

  always_comb begin
    strobes.driveEn   = !away;
    strobes.setHang   = hangNow;
    strobes.clrHang   = !away;
    strobes.latchMode = takeGrant;
  end
endmodule

// File: rtl/xbus_grant_dp.sv
module xbus_grant_dp
  import xbus_grant_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 24,
  parameter int STRB_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobes_t       strobes,
  input  logic              runWhileGranted,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreData,
  input  logic [STRB_W-1:0] coreStrobe,
  output logic              modeRun,
  output logic              hangHeld,
  output logic              pinsDriven,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extData,
  output logic [STRB_W-1:0] extStrobe
);
  localparam int PIN_W = ADDR_W + DATA_W + STRB_W;

  logic [PIN_W-1:0] pinOut, pinBus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeRun  <= 1'b0;
      hangHeld <= 1'b0;
    end else begin
      if (strobes.latchMode) modeRun <= runWhileGranted;
      if (strobes.clrHang)      hangHeld <= 1'b0;
      else if (strobes.setHang) hangHeld <= 1'b1;
    end
  end

  assign pinOut = {coreAddr, coreData, coreStrobe};

  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    assign pinBus[i] = strobes.driveEn ? pinOut[i] : 1'bz;
  end

  assign pinsDriven = strobes.driveEn;
  assign extAddr    = pinBus[PIN_W-1 -: ADDR_W];
  assign extData    = pinBus[STRB_W +: DATA_W];
  assign extStrobe  = pinBus[STRB_W-1:0];
endmodule

// File: rtl/xbus_grant_arb.sv
module xbus_grant_arb
  import xbus_grant_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 24,
  parameter int STRB_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              runWhileGranted,
  input  logic              extCycleBusy,
  input  logic              coreExtReq,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreData,
  input  logic [STRB_W-1:0] coreStrobe,
  output logic              busGrant,
  output logic              grantHang,
  output logic              coreStall,
  output logic              onChipOnly,
  output logic              pinsDriven,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extData,
  output logic [STRB_W-1:0] extStrobe
);
  arbStrobes_t strobes;
  logic modeRun, hangHeld;

  xbus_grant_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .extCycleBusy(extCycleBusy),
    .coreExtReq(coreExtReq), .modeRun(modeRun), .hangHeld(hangHeld),
    .strobes(strobes), .busGrant(busGrant), .grantHang(grantHang),
    .coreStall(coreStall), .onChipOnly(onChipOnly)
  );

  xbus_grant_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRB_W(STRB_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .runWhileGranted(runWhileGranted),
    .coreAddr(coreAddr), .coreData(coreData), .coreStrobe(coreStrobe),
    .modeRun(modeRun), .hangHeld(hangHeld), .pinsDriven(pinsDriven),
    .extAddr(extAddr), .extData(extData), .extStrobe(extStrobe)
  );
endmodule

// File: rtl/xbus_grant_chk.sv
module xbus_grant_chk (
  input logic clk,
  input logic rstN,
  input logic busReq,
  input logic extCycleBusy,
  input logic busGrant,
  input logic grantHang,
  input logic coreStall,
  input logic onChipOnly,
  input logic pinsDriven
);
  a_r2_no_grant_mid_cycle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busGrant) |-> $past(!extCycleBusy && busReq));

  a_r3_pins_off_when_granted: assert property (@(posedge clk) disable iff (!rstN)
    busGrant |-> !pinsDriven);

  a_r4_halt_while_granted: assert property (@(posedge clk) disable iff (!rstN)
    (busGrant && !onChipOnly) |-> coreStall);

  a_r6_hang_stalls_core: assert property (@(posedge clk) disable iff (!rstN)
    grantHang |-> (coreStall && !pinsDriven));

  a_r7_release_next_clock: assert property (@(posedge clk) disable iff (!rstN)
    (busGrant && !busReq) |=> !busGrant);

  a_r7_owner_returns: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busGrant) |=> pinsDriven);

  a_r9_owned_gap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busGrant) |=> !busGrant);
endmodule

bind xbus_grant_arb xbus_grant_chk u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .extCycleBusy(extCycleBusy),
  .busGrant(busGrant), .grantHang(grantHang), .coreStall(coreStall),
  .onChipOnly(onChipOnly), .pinsDriven(pinsDriven)
);

// File: tb/xbus_grant_arb_test.sv
module xbus_grant_arb_test;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 24;
  localparam int STRB_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReq = 1'b0, runWhileGranted = 1'b0, extCycleBusy = 1'b0, coreExtReq = 1'b0;
  logic [ADDR_W-1:0] coreAddr = 14'h1A5C;
  logic [DATA_W-1:0] coreData = 24'hC3A517;
  logic [STRB_W-1:0] coreStrobe = 4'b1010;
  logic busGrant, grantHang, coreStall, onChipOnly, pinsDriven;
  wire [ADDR_W-1:0] extAddr;
  wire [DATA_W-1:0] extData;
  wire [STRB_W-1:0] extStrobe;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;

  xbus_grant_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRB_W(STRB_W)) uut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .runWhileGranted(runWhileGranted),
    .extCycleBusy(extCycleBusy), .coreExtReq(coreExtReq), .coreAddr(coreAddr),
    .coreData(coreData), .coreStrobe(coreStrobe), .busGrant(busGrant),
    .grantHang(grantHang), .coreStall(coreStall), .onChipOnly(onChipOnly),
    .pinsDriven(pinsDriven), .extAddr(extAddr), .extData(extData), .extStrobe(extStrobe)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chkCtl(input string tag, input logic g, input logic h,
                        input logic s, input logic o, input logic d);
    chk({tag, " grant"}, 64'(busGrant), 64'(g));
    chk({tag, " hang"}, 64'(grantHang), 64'(h));
    chk({tag, " stall"}, 64'(coreStall), 64'(s));
    chk({tag, " onChipOnly"}, 64'(onChipOnly), 64'(o));
    chk({tag, " drive"}, 64'(pinsDriven), 64'(d));
  endtask

  task automatic chkPins(input string tag, input logic driven);
    if (driven) begin
      chk({tag, " addr"}, 64'(extAddr), 64'(coreAddr));
      chk({tag, " data"}, 64'(extData), 64'(coreData));
      chk({tag, " strobe"}, 64'(extStrobe), 64'(coreStrobe));
    end else begin
      chk({tag, " addr z"}, {50'd0, extAddr}, {50'd0, {ADDR_W{1'bz}}});
      chk({tag, " data z"}, {40'd0, extData}, {40'd0, {DATA_W{1'bz}}});
      chk({tag, " strobe z"}, {60'd0, extStrobe}, {60'd0, {STRB_W{1'bz}}});
    end
  endtask

  task automatic testReset();
    chkCtl("R1 in reset", 0, 0, 0, 0, 1);
    chkPins("R1 in reset", 1);
    step();
    rstN = 1'b1;
    step();
    chkCtl("R1 after reset", 0, 0, 0, 0, 1);
    chkPins("R1 after reset", 1);
  endtask

  task automatic testHaltGrant();
    runWhileGranted = 1'b0;
    busReq = 1'b1;
    step();
    chkCtl("R4 granted", 1, 0, 1, 0, 0);
    chkPins("R3 granted", 0);
    runWhileGranted = 1'b1;
    step();
    chkCtl("R8 mode change ignored", 1, 0, 1, 0, 0);
    busReq = 1'b0;
    runWhileGranted = 1'b0;
    step();
    chkCtl("R7 release cycle", 0, 0, 1, 0, 0);
    chkPins("R3 release cycle", 0);
    step();
    chkCtl("R7 owned again", 0, 0, 0, 0, 1);
    chkPins("R7 owned again", 1);
  endtask

  task automatic testBusyDefers();
    extCycleBusy = 1'b1;
    busReq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R2 no grant while busy", 64'(busGrant), 64'd0);
    end
    extCycleBusy = 1'b0;
    step();
    chk("R2 grant after busy ends", 64'(busGrant), 64'd1);
    busReq = 1'b0;
    step();
    step();
  endtask

  task automatic testRunHang();
    runWhileGranted = 1'b1;
    busReq = 1'b1;
    step();
    chkCtl("R5 run granted", 1, 0, 0, 1, 0);
    runWhileGranted = 1'b0;
    step();
    chkCtl("R8 run mode kept", 1, 0, 0, 1, 0);
    coreExtReq = 1'b1;
    #1;
    chkCtl("R6 hang same cycle", 1, 1, 1, 1, 0);
    step();
    coreExtReq = 1'b0;
    #1;
    chkCtl("R6 hang sticky", 1, 1, 1, 1, 0);
    busReq = 1'b0;
    step();
    chkCtl("R6 hang in release", 0, 1, 1, 1, 0);
    step();
    chkCtl("R7 hang cleared", 0, 0, 0, 0, 1);
    chkPins("R7 run owned", 1);
  endtask

  task automatic testRegrantGap();
    runWhileGranted = 1'b0;
    busReq = 1'b1;
    step();
    chk("R9 first grant", 64'(busGrant), 64'd1);
    busReq = 1'b0;
    step();
    busReq = 1'b1;
    chk("R9 released", 64'(busGrant), 64'd0);
    step();
    chkCtl("R9 owned gap", 0, 0, 0, 0, 1);
    step();
    chk("R9 regrant", 64'(busGrant), 64'd1);
    busReq = 1'b0;
    step();
    step();
  endtask

  initial begin
    #(8 * 20000);
    testsFailed++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #1;
    testReset();
    testHaltGrant();
    testBusyDefers();
    testRunHang();
    testRegrantGap();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule